// File: doc/BRIEF.md
# Ready-to-Acknowledge Synchronizer with Blanking

This block sits on the host side of a memory bus that talks to a slave with an asynchronous ready output. The host keeps adding wait states until it sees an acknowledge. The block produces that acknowledge from the slave's ready, retimed to the host memory clock. The acknowledge line is shared with other bus slaves, so the block also gives an output enable. That enable is raised only while this block asserts the acknowledge.

The slave shows a false high ready while it is deselected. It also keeps showing it for a short time after its select asserts, until its own logic answers. The block ignores ready in both periods. A timer blocks capture for a fixed number of host clocks after select asserts, computed from the clock period and a blanking time in picoseconds. When select negates, the acknowledge and the timer clear at once without waiting for a clock edge, so a back-to-back select gets the full blanking window again. Each select gives at most one single-cycle acknowledge.

Top module: `rdy_ack_sync`

## Requirements
- R1: While rst_ni is low, ack_o and ack_oe_o are low, and they stay low after reset until a capture.
- R2: While cs_ni is high (deselected), ack_o stays low whatever rdy_i does.
- R3: After cs_ni falls, no acknowledge is captured on the first BLANK_CYCLES = ceil(BLANK_PS / CLK_PERIOD_PS) rising clock edges. With rdy_i held high from the select onward, ack_o first goes high on edge BLANK_CYCLES+1.
- R4: rdy_i passes through SYNC_STAGES flops before capture. Once the window is open, ack_o rises on the (SYNC_STAGES+1)-th rising edge that samples rdy_i high, counting that first edge as 1.
- R5: ack_o is high for exactly one clock per select and does not rise again until cs_ni has gone high and then low.
- R6: When cs_ni goes high, ack_o and ack_oe_o go low at once, before the next clock edge.
- R7: After any deselect of one clock or more, a new select applies the full BLANK_CYCLES window again.
- R8: ack_oe_o is high exactly when ack_o is high, so the shared line is driven only while the acknowledge is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Slave chip select, active low |
| rdy_i | input | 1 | Asynchronous slave ready, active high |
| ack_o | output | 1 | Transfer acknowledge, active high |
| ack_oe_o | output | 1 | Output enable for the shared acknowledge line |

## Verification
The bench uses CLK_PERIOD_PS = 20000 to match its 50 MHz clock, BLANK_PS = 150000 and SYNC_STAGES = 2. This gives an 8-edge blanking window, which is longer than the synchroniser depth. With these values the bench can tell a false ready still in the pipeline from a real one. It also measures the exact edge of the first acknowledge after a select and after a late ready. Deselects of a single clock test whether the timer restarts, and select windows shorter than 8 edges test that no acknowledge gets through.

// File: rtl/rdy_ack_pkg.sv
package rdy_ack_pkg;
  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= 1'b0;
        else         stage_q[i] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= 1'b0;
        else         stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int unsigned CYCLES = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic clk_i,
  input  logic clr_ni,   // low while deselected or in reset
  output logic open_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // async clear gives full-window recovery on back-to-back selects
  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni)            cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = (cnt_q == LIMIT);

  a_r3_cnt_bounded: assert property (@(posedge clk_i) disable iff (!clr_ni)
    cnt_q <= LIMIT);

  a_r7_open_needs_full_count: assert property (@(posedge clk_i) disable iff (!clr_ni)
    $rose(open_o) |-> $past(cnt_q) == LIMIT - 1'b1);
endmodule

// File: rtl/ack_capture.sv
module ack_capture (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic open_i,
  input  logic rdy_i,
  output logic ack_o
);
  logic ack_q;
  logic done_q;
  logic ack_d;

  assign ack_d = open_i & rdy_i & ~done_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      ack_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ack_q  <= ack_d;
      done_q <= done_q | ack_d;
    end
  end

  assign ack_o = ack_q;

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!clr_ni)
    ack_q |=> !ack_q);

  a_r3_capture_only_when_open: assert property (@(posedge clk_i) disable iff (!clr_ni)
    $rose(ack_q) |-> $past(open_i));

  a_r4_capture_needs_sync_ready: assert property (@(posedge clk_i) disable iff (!clr_ni)
    $rose(ack_q) |-> $past(rdy_i));
endmodule

// File: rtl/rdy_ack_sync.sv
module rdy_ack_sync
  import rdy_ack_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned BLANK_PS      = 150000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rdy_i,
  output logic ack_o,
  output logic ack_oe_o
);
  localparam int unsigned BLANK_CYCLES = ceil_div(BLANK_PS, CLK_PERIOD_PS);
  localparam int unsigned CNT_W        = $clog2(BLANK_CYCLES + 1);

  logic sel_clr_n;
  logic rdy_s;
  logic win_open;
  logic ack_q;

  // deselect or reset clears timer and acknowledge without a clock
  assign sel_clr_n = rst_ni & ~cs_ni;

  rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(rdy_i),
    .sync_o (rdy_s)
  );

  blank_timer #(.CYCLES(BLANK_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .clr_ni(sel_clr_n),
    .open_o(win_open)
  );

  ack_capture u_cap (
    .clk_i (clk_i),
    .clr_ni(sel_clr_n),
    .open_i(win_open),
    .rdy_i (rdy_s),
    .ack_o (ack_q)
  );

  assign ack_o    = ack_q;
  assign ack_oe_o = ack_q;

  a_r2_quiet_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !ack_o);

  a_r6_cleared_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_ni) |-> !ack_oe_o);
endmodule

// File: tb/rdy_ack_sync_bench.sv
`timescale 1ns/1ps
module rdy_ack_sync_bench;
  localparam int CLK_PS  = 20000;
  localparam int BLANK   = 150000;
  localparam int STAGES  = 2;
  localparam int B       = (BLANK + CLK_PS - 1) / CLK_PS;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1;
  logic rdy_i = 1'b1;
  logic ack_o, ack_oe_o;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #10 clk_i = ~clk_i;

  rdy_ack_sync #(.CLK_PERIOD_PS(CLK_PS), .BLANK_PS(BLANK), .SYNC_STAGES(STAGES)) u_rdy_ack_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .rdy_i(rdy_i),
    .ack_o(ack_o), .ack_oe_o(ack_oe_o)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated every clock
  int   sel_cyc = 0;
  bit   done = 0, exp_ack = 0, rdy_m1 = 0, rdy_m2 = 0, use_rdy;
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      sel_cyc = 0; done = 0; exp_ack = 0; rdy_m1 = 0; rdy_m2 = 0;
    end else begin
      use_rdy = rdy_m2;
      if (cs_ni) begin
        sel_cyc = 0; done = 0; exp_ack = 0;
      end else begin
        exp_ack = (sel_cyc >= B) && use_rdy && !done;
        if (exp_ack) done = 1;
        if (sel_cyc < 1000) sel_cyc++;
      end
      rdy_m2 = rdy_m1;
      rdy_m1 = rdy_i;
    end
    #5;
    check(cur_req, ack_o, exp_ack, "ack_o vs model");
    check("R8", ack_oe_o, ack_o, "ack_oe_o tracks ack_o");
  end

  // count posedges until ack seen high; 0 if not seen within limit
  task automatic wait_ack(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk_i); #1;
      if (ack_o) begin n = i; return; end
    end
  endtask

  task automatic count_acks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk_i); #1;
      if (ack_o) n++;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n;
    // R1: reset
    repeat (3) @(negedge clk_i);
    check("R1", ack_o, 1'b0, "ack_o in reset");
    check("R1", ack_oe_o, 1'b0, "ack_oe_o in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", ack_oe_o, 1'b0, "ack_oe_o after reset");

    // R2: deselected, ready toggling
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i); rdy_i = i[0];
    end
    count_acks(2, n);
    check_int("R2", n, 0, "acks while deselected");

    // R3/R5: select with false ready held high
    cur_req = "R3";
    @(negedge clk_i); rdy_i = 1'b1; cs_ni = 1'b0;
    wait_ack(40, n);
    check_int("R3", n, B + 1, "edge of first ack after select");
    cur_req = "R5";
    count_acks(10, n);
    check_int("R5", n, 0, "extra acks in same select");
    @(negedge clk_i); cs_ni = 1'b1;

    // R4: slave late ready
    cur_req = "R4";
    @(negedge clk_i); @(negedge clk_i); rdy_i = 1'b0;
    @(negedge clk_i); cs_ni = 1'b0;
    repeat (B + 4) @(negedge clk_i);
    rdy_i = 1'b1;
    wait_ack(20, n);
    check_int("R4", n, STAGES + 1, "edges from ready to ack");
    @(negedge clk_i); cs_ni = 1'b1; rdy_i = 1'b1;

    // R6: deselect during the ack cycle
    cur_req = "R6";
    @(negedge clk_i); cs_ni = 1'b0;
    wait_ack(40, n);
    check("R6", ack_o, 1'b1, "ack high before deselect");
    #4; cs_ni = 1'b1; #1;
    check("R6", ack_o, 1'b0, "ack cleared without clock");
    check("R6", ack_oe_o, 1'b0, "oe cleared without clock");

    // R7: back-to-back select after one-clock deselect
    cur_req = "R7";
    @(negedge clk_i); cs_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    cs_ni = 1'b1;
    @(negedge clk_i); cs_ni = 1'b0;
    wait_ack(40, n);
    check_int("R7", n, B + 1, "full window after short deselect");
    @(negedge clk_i); cs_ni = 1'b1;
    @(negedge clk_i); cs_ni = 1'b0;
    wait_ack(40, n);
    check_int("R7", n, B + 1, "full window after one-clock gap");

    // R3: select shorter than window yields nothing
    cur_req = "R3";
    @(negedge clk_i); cs_ni = 1'b1;
    @(negedge clk_i); cs_ni = 1'b0;
    count_acks(B - 1, n);
    @(negedge clk_i); cs_ni = 1'b1;
    count_acks(3, n);
    check_int("R3", n, 0, "no ack from short select");

    // R5: new select gives new pulse
    cur_req = "R5";
    @(negedge clk_i); cs_ni = 1'b0;
    count_acks(B + 12, n);
    check_int("R5", n, 1, "one ack per select");
    @(negedge clk_i); cs_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule